// File: doc/BRIEF.md
# LCD Frame Interrupt and Write-Window Controller

This block produces the frame timing for a multiplexed segment LCD driver. A cycle counter steps a common-phase index through one to four commons. Each common holds for a programmable number of clock cycles, called the slot length. A frame starts when the index returns to common 0. The block also decides when software may update pixel data. In Type-B multiplexed drive, pixel data has to stay the same across an even/odd frame pair. For that mode the block opens a write window only in the second half of every odd frame. It raises a sticky interrupt when that window opens and flags any write strobe that arrives while the window is shut.

The mux select, waveform select and slot length are sampled during reset and again at every frame boundary. A frame is therefore never cut short. In Type-A drive, and in Type-B drive with a single common, there is no interrupt and writes are always permitted. The block carries no pixel data. Its pins are plain control and status signals with no handshake, so no back-pressure applies.

Top module: `lcd_frame_ctrl`

## Requirements
- R1: `com_o` runs 0, 1, … up to the latched mux select and then back to 0. Each value is held for the latched slot length in cycles. A slot length below 2 is treated as 2.
- R2: `mux_sel_i`, `type_b_i` and `slot_len_i` are sampled while `rst_n` is low and in the last cycle of each frame. They have no effect at any other time.
- R3: In Type-B drive with a mux select other than 0, let F = (mux select + 1) × slot length and let p be the cycle's position in the frame, 0 to F−1. In odd frames, `wr_en_o` is high exactly where p ≥ floor(F/2), so the window lasts ceil(F/2) cycles and closes at the frame boundary. In even frames `wr_en_o` is low throughout. The first frame after reset is even, and frames alternate from then on.
- R4: In that same mode, `irq_o` becomes 1 on the cycle after the window opens in an odd frame. It never rises at any other time.
- R5: With `type_b_i` = 0, or with a mux select of 0, `wr_en_o` is held at 1 and `irq_o` never rises.
- R6: A `wr_i` pulse in a cycle where `wr_en_o` is 0 sets `wr_err_o` from the next cycle on. A `wr_i` pulse while `wr_en_o` is 1 does not set it.
- R7: `irq_o` and `wr_err_o` stay set until `irq_clr_i` or `err_clr_i` respectively is high at a clock edge. A clear wins over a set that happens in the same cycle.
- R8: While `rst_n` is low, `com_o`, `irq_o` and `wr_err_o` are cleared and the frame position and parity return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_sel_i | input | 2 | Number of active commons minus one |
| type_b_i | input | 1 | 1 selects Type-B waveforms, 0 selects Type-A |
| slot_len_i | input | LEN_W | Cycles per common phase |
| wr_i | input | 1 | Pixel-write attempt strobe |
| irq_clr_i | input | 1 | Clears the frame interrupt |
| err_clr_i | input | 1 | Clears the write-error flag |
| com_o | output | 2 | Active common index |
| irq_o | output | 1 | Sticky frame interrupt |
| wr_en_o | output | 1 | Pixel-write window open |
| wr_err_o | output | 1 | Sticky write-error flag |

## Verification
The bench changes the configuration in the middle of a frame and checks that the common sequence keeps its old length until the boundary. A design that sampled the configuration early would cut frames short or skip commons. Slot lengths of 0, 1 and 2 test the clamp and the smallest window. An off-by-one in the window start would show up there as a window one cycle too long or too short, or as an interrupt a cycle late. Frame parity is tracked across mode changes, so an interrupt in an even frame, or one under Type-A or static drive, is caught. Clear and set strobes collide often enough to test clear priority, and write strobes fall both inside and just outside the window.

// File: rtl/lcd_ft_pkg.sv
package lcd_ft_pkg;
  localparam int unsigned COM_W = 2;
  typedef logic [COM_W-1:0] com_t;

  function automatic logic is_muxed_b(input logic type_b, input com_t mux);
    return type_b && (mux != '0);
  endfunction
endpackage

// File: rtl/lcd_ft_timing.sv
module lcd_ft_timing
  import lcd_ft_pkg::*;
#(
  parameter int unsigned LEN_W = 8,
  localparam int unsigned POS_W = LEN_W + COM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  com_t             mux_sel_i,
  input  logic             type_b_i,
  input  logic [LEN_W-1:0] slot_len_i,
  output com_t             com_o,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] frame_len_o,
  output com_t             mux_q_o,
  output logic             type_b_q_o,
  output logic             odd_o
);
  localparam logic [LEN_W-1:0] MIN_SLOT = LEN_W'(2);

  logic [LEN_W-1:0] slot_eff, slot_q, slot_cnt;
  com_t             mux_q, com_q;
  logic             type_b_q, odd_q;
  logic [POS_W-1:0] pos_q;
  logic             slot_end, frame_end;

  assign slot_eff  = (slot_len_i < MIN_SLOT) ? MIN_SLOT : slot_len_i;
  assign slot_end  = (slot_cnt == slot_q - LEN_W'(1));
  assign frame_end = slot_end && (com_q == mux_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mux_q    <= mux_sel_i;
      type_b_q <= type_b_i;
      slot_q   <= slot_eff;
      slot_cnt <= '0;
      com_q    <= '0;
      pos_q    <= '0;
      odd_q    <= 1'b0;
    end else if (frame_end) begin
      mux_q    <= mux_sel_i;
      type_b_q <= type_b_i;
      slot_q   <= slot_eff;
      slot_cnt <= '0;
      com_q    <= '0;
      pos_q    <= '0;
      odd_q    <= ~odd_q;
    end else if (slot_end) begin
      slot_cnt <= '0;
      com_q    <= com_q + com_t'(1);
      pos_q    <= pos_q + POS_W'(1);
    end else begin
      slot_cnt <= slot_cnt + LEN_W'(1);
      pos_q    <= pos_q + POS_W'(1);
    end
  end

  assign frame_len_o = POS_W'({1'b0, mux_q} + 3'd1) * POS_W'(slot_q);
  assign com_o       = com_q;
  assign pos_o       = pos_q;
  assign mux_q_o     = mux_q;
  assign type_b_q_o  = type_b_q;
  assign odd_o       = odd_q;
endmodule

// File: rtl/lcd_ft_window.sv
module lcd_ft_window
  import lcd_ft_pkg::*;
#(
  parameter int unsigned POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] frame_len_i,
  input  com_t             mux_q_i,
  input  logic             type_b_q_i,
  input  logic             odd_i,
  input  logic             irq_clr_i,
  output logic             wr_en_o,
  output logic             irq_o
);
  logic [POS_W-1:0] open_pos;
  logic             gated, irq_q, irq_set;

  assign open_pos = frame_len_i >> 1;
  assign gated    = is_muxed_b(type_b_q_i, mux_q_i);
  assign wr_en_o  = gated ? (odd_i && (pos_i >= open_pos)) : 1'b1;
  assign irq_set  = gated && odd_i && (pos_i == open_pos);

  always_ff @(posedge clk) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (irq_clr_i) irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/lcd_ft_guard.sv
module lcd_ft_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wr_en_i,
  input  logic err_clr_i,
  output logic wr_err_o
);
  logic err_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                err_q <= 1'b0;
    else if (err_clr_i)        err_q <= 1'b0;
    else if (wr_i && !wr_en_i) err_q <= 1'b1;
  end

  assign wr_err_o = err_q;
endmodule

// File: rtl/lcd_frame_ctrl.sv
module lcd_frame_ctrl
  import lcd_ft_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mux_sel_i,
  input  logic             type_b_i,
  input  logic [LEN_W-1:0] slot_len_i,
  input  logic             wr_i,
  input  logic             irq_clr_i,
  input  logic             err_clr_i,
  output logic [1:0]       com_o,
  output logic             irq_o,
  output logic             wr_en_o,
  output logic             wr_err_o
);
  localparam int unsigned POS_W = LEN_W + COM_W;

  logic [POS_W-1:0] pos, frame_len;
  com_t             mux_q;
  logic             type_b_q, odd;

  lcd_ft_timing #(.LEN_W(LEN_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .mux_sel_i(mux_sel_i), .type_b_i(type_b_i),
    .slot_len_i(slot_len_i), .com_o(com_o), .pos_o(pos),
    .frame_len_o(frame_len), .mux_q_o(mux_q), .type_b_q_o(type_b_q),
    .odd_o(odd)
  );

  lcd_ft_window #(.POS_W(POS_W)) u_window (
    .clk(clk), .rst_n(rst_n), .pos_i(pos), .frame_len_i(frame_len),
    .mux_q_i(mux_q), .type_b_q_i(type_b_q), .odd_i(odd),
    .irq_clr_i(irq_clr_i), .wr_en_o(wr_en_o), .irq_o(irq_o)
  );

  lcd_ft_guard u_guard (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .wr_en_i(wr_en_o),
    .err_clr_i(err_clr_i), .wr_err_o(wr_err_o)
  );
endmodule

// File: rtl/lcd_frame_ctrl_chk.sv
module lcd_frame_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] com_o,
  input logic [1:0] mux_q,
  input logic       type_b_q,
  input logic       wr_i,
  input logic       irq_clr_i,
  input logic       err_clr_i,
  input logic       irq_o,
  input logic       wr_en_o,
  input logic       wr_err_o
);
  AST_COM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(com_o) |-> (com_o == 2'd0 || com_o == 2'($past(com_o) + 2'd1))); // R1
  AST_COM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    com_o <= mux_q); // R1
  AST_IRQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> wr_en_o); // R4
  AST_PLAIN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!type_b_q || mux_q == 2'd0) |-> wr_en_o); // R5
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wr_en_o && !err_clr_i) |=> wr_err_o); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o); // R7
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_i |=> !irq_o); // R7
  AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_i |=> !wr_err_o); // R7
endmodule

bind lcd_frame_ctrl lcd_frame_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .com_o(com_o), .mux_q(mux_q),
  .type_b_q(type_b_q), .wr_i(wr_i), .irq_clr_i(irq_clr_i),
  .err_clr_i(err_clr_i), .irq_o(irq_o), .wr_en_o(wr_en_o),
  .wr_err_o(wr_err_o)
);

// File: tb/lcd_frame_ctrl_test.sv
module lcd_frame_ctrl_test;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mux_sel_i = 2'd3;
  logic             type_b_i = 1'b1;
  logic [LEN_W-1:0] slot_len_i = 8'd3;
  logic             wr_i = 1'b0, irq_clr_i = 1'b0, err_clr_i = 1'b0;
  logic [1:0]       com_o;
  logic             irq_o, wr_en_o, wr_err_o;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_mux, m_tb, m_slot, m_sc, m_com, m_pos, m_odd, m_irq, m_err;

  lcd_frame_ctrl #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .mux_sel_i(mux_sel_i), .type_b_i(type_b_i),
    .slot_len_i(slot_len_i), .wr_i(wr_i), .irq_clr_i(irq_clr_i),
    .err_clr_i(err_clr_i), .com_o(com_o), .irq_o(irq_o),
    .wr_en_o(wr_en_o), .wr_err_o(wr_err_o)
  );

  always #10 clk = ~clk;

  function automatic int eff_slot(input int s);
    return (s < 2) ? 2 : s;
  endfunction

  function automatic bit gated(input int tb, input int mux);
    return (tb != 0) && (mux != 0);
  endfunction

  function automatic int exp_wr_en();
    int f;
    f = (m_mux + 1) * m_slot;
    if (!gated(m_tb, m_mux)) return 1;
    return (m_odd != 0 && m_pos >= f / 2) ? 1 : 0;
  endfunction

  function automatic bit exp_irq_set();
    int f;
    f = (m_mux + 1) * m_slot;
    return gated(m_tb, m_mux) && m_odd != 0 && m_pos == f / 2;
  endfunction

  task automatic load_cfg();
    m_mux = int'(mux_sel_i); m_tb = int'(type_b_i); m_slot = eff_slot(int'(slot_len_i));
  endtask

  always @(posedge clk) begin
    int w;
    bit iset;
    w = exp_wr_en();
    iset = exp_irq_set();
    if (!rst_n) begin
      load_cfg();
      m_sc = 0; m_com = 0; m_pos = 0; m_odd = 0; m_irq = 0; m_err = 0;
    end else begin
      if (irq_clr_i) m_irq = 0; else if (iset) m_irq = 1;
      if (err_clr_i) m_err = 0; else if (wr_i && w == 0) m_err = 1;
      if (m_sc == m_slot - 1) begin
        m_sc = 0;
        if (m_com == m_mux) begin
          load_cfg(); m_com = 0; m_pos = 0; m_odd = 1 - m_odd;
        end else begin
          m_com++; m_pos++;
        end
      end else begin
        m_sc++; m_pos++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  bit last_clr_irq, last_clr_err;

  task automatic compare_all();
    chk("R1/R2 com", int'(com_o), m_com);
    chk(gated(m_tb, m_mux) ? "R3 window" : "R5 window", int'(wr_en_o), exp_wr_en());
    chk(last_clr_irq ? "R7 irq clear" : "R4 irq", int'(irq_o), m_irq);
    chk(last_clr_err ? "R7 err clear" : "R6 err", int'(wr_err_o), m_err);
  endtask

  task automatic run(input int n, input int wr_pct, input int clr_pct, input int cfg_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      wr_i      = ($urandom % 100) < wr_pct;
      irq_clr_i = ($urandom % 100) < clr_pct;
      err_clr_i = ($urandom % 100) < clr_pct;
      last_clr_irq = irq_clr_i;
      last_clr_err = err_clr_i;
      if (($urandom % 100) < cfg_pct) begin
        mux_sel_i  = 2'($urandom);
        type_b_i   = 1'($urandom);
        slot_len_i = LEN_W'($urandom % 7);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk("R8 com", int'(com_o), 0);
    chk("R8 irq", int'(irq_o), 0);
    chk("R8 err", int'(wr_err_o), 0);
    rst_n = 1'b1;
    // R3/R4: quarter duty Type-B, even frame then odd
    run(60, 10, 0, 0);
    // R7: irq must be sticky here; then clear
    @(negedge clk);
    chk("R7 irq sticky", int'(irq_o), 1);
    irq_clr_i = 1'b1; last_clr_irq = 1'b1;
    @(negedge clk);
    chk("R7 irq cleared", int'(irq_o), 0);
    irq_clr_i = 1'b0; last_clr_irq = 1'b0;
    // R2/R5: switch to Type-A mid frame, then static Type-B
    mux_sel_i = 2'd2; type_b_i = 1'b0; slot_len_i = 8'd1;
    run(80, 30, 5, 0);
    mux_sel_i = 2'd0; type_b_i = 1'b1; slot_len_i = 8'd0;
    run(80, 30, 5, 0);
    // R3: smallest multiplexed frame, two commons of two cycles
    mux_sel_i = 2'd1; type_b_i = 1'b1; slot_len_i = 8'd2;
    run(120, 25, 5, 0);
    // random mix
    run(20000, 15, 4, 3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule